// File: doc/BRIEF.md
# Prescaled Coulomb Counter Core

This block is the digital heart of a battery charge gauge. An analog front end, which lies outside this block, delivers one-cycle charge-quantum pulses, each tagged with a direction. A power-of-two prescaler selected by software divides these pulses. Each prescaler overflow moves a saturating 16-bit accumulated-charge value one step up or down. At power-up this value sits at mid-scale because the battery state is unknown.

The accumulated value is compared every cycle against a host-programmed high limit and low limit. Crossings set sticky status flags, and a digital undervoltage indication sets a third flag. One shared pin serves two roles, chosen by a control field. It can be an open-drain alert output that is pulled low while any flag is set. It can instead be a charge-complete input that forces the accumulator to full scale.

A simple byte-wide register port stands in for the serial bus. Reading the high byte of the accumulator captures the low byte, so a two-read sequence always returns one coherent 16-bit sample.

Top module: `cgauge_top`

## Requirements
- R1: After reset the register map reads: address 0 status = 00h, address 1 control = 38h (prescale exponent 7, pin mode 00, run), addresses 2/3 accumulator high/low = 7Fh/FFh, addresses 4/5 high limit = FFh/FFh, addresses 6/7 low limit = 00h/00h. The shared pin is not pulled low.
- R2: The prescale factor is M = 2^control[5:3]. Every M-th accepted charge pulse steps the accumulator by one, upward when q_up is 1 and downward when q_up is 0. The direction is taken from the pulse that completes the count.
- R3: The accumulator saturates. A step up at FFFFh leaves FFFFh, and a step down at 0000h leaves 0000h.
- R4: While control[0] is 1 (front end shut down), charge pulses are ignored. The accumulator does not change and the prescaler does not count.
- R5: Host writes to addresses 1 through 7 replace that byte. Address 2 holds the accumulator high byte and address 3 the low byte. A host write to the accumulator takes precedence over a prescaler step in the same cycle.
- R6: A read of address 2 captures the current low byte. The next read of address 3 returns that captured byte even if the accumulator changed in between. A read of address 3 with no pending capture returns the live low byte.
- R7: Status bit 3 is set while the accumulator is above the high limit, and status bit 2 is set while it is below the low limit. Both are sticky. A status read clears a flag whose condition no longer holds.
- R8: A high level on uv_in sets status bit 1, which is sticky and is cleared by a status read once uv_in is low. Status bits 7:4 and 0 read as 0.
- R9: Control[2:1] sets the pin mode: 00 disabled, 01 charge-complete input, 10 alert output, 11 disabled. pin_pull_low is 1 only in mode 10 while any status flag is set. In the other modes, pin_in has no effect unless the mode is 01.
- R10: In mode 01 a high pin_in forces the accumulator to FFFFh on the next edge. This takes precedence over host writes and pulses, and it also applies while the front end is shut down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| q_pulse | input | 1 | One-cycle charge-quantum pulse |
| q_up | input | 1 | Direction of the pulse, 1 = charging |
| uv_in | input | 1 | Battery undervoltage indication |
| pin_in | input | 1 | Sensed level of the shared alert/charge-complete pin |
| pin_pull_low | output | 1 | Open-drain pull-down enable for the shared pin |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; read side effects occur at the clock edge |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, valid in the cycle of reg_rd |

## Verification
A prescaler that has lost its count shows up as an accumulator step arriving one or more pulses early or late. It is visible at the next byte read after the M-th pulse, so the bench counts pulses exactly around each step boundary and reads back both bytes. A wrong flag or threshold compare appears at the status read and on pin_pull_low in the cycle after the accumulator change. A stale or missing low-byte capture appears only when a step falls between the two reads, so one test places a pulse in exactly that gap.

// File: rtl/cg_pkg.sv
package cg_pkg;

  typedef enum logic [2:0] {
    A_STAT = 3'd0,
    A_CTRL = 3'd1,
    A_ACCH = 3'd2,
    A_ACCL = 3'd3,
    A_HIH  = 3'd4,
    A_HIL  = 3'd5,
    A_LOH  = 3'd6,
    A_LOL  = 3'd7
  } reg_addr_e;

  typedef enum logic [1:0] {
    PM_OFF     = 2'b00,
    PM_CHGDONE = 2'b01,
    PM_ALERT   = 2'b10,
    PM_RSVD    = 2'b11
  } pin_mode_e;

  localparam int CTRL_SHDN_BIT = 0;
  localparam int CTRL_MODE_LSB = 1;
  localparam int CTRL_EXP_LSB  = 3;

endpackage

// File: rtl/cg_prescaler.sv
module cg_prescaler #(
  parameter int EXP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             pulse,
  input  logic [EXP_W-1:0] exp_sel,
  output logic             step
);
  localparam int CNT_W = (1 << EXP_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] lim;
  logic             cnt_en;

  always_comb begin
    lim    = ~({CNT_W{1'b1}} << exp_sel);
    cnt_en = run & pulse;
    step   = cnt_en & (cnt_q >= lim);
    cnt_d  = step ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/cg_accum.sv
module cg_accum #(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step,
  input  logic                dir_up,
  input  logic                preset,
  input  logic                wr_hi,
  input  logic                wr_lo,
  input  logic [DATA_W-1:0]   wdata,
  output logic [2*DATA_W-1:0] acc_q
);
  localparam int ACC_W = 2 * DATA_W;
  localparam logic [ACC_W-1:0] ACC_MAX = {ACC_W{1'b1}};
  localparam logic [ACC_W-1:0] ACC_MID = {1'b0, {(ACC_W-1){1'b1}}};

  logic [ACC_W-1:0] acc_d;
  logic             acc_en;

  always_comb begin
    acc_d  = acc_q;
    acc_en = 1'b0;
    if (preset) begin
      acc_d  = ACC_MAX;
      acc_en = 1'b1;
    end else if (wr_hi || wr_lo) begin
      if (wr_hi) acc_d[ACC_W-1:DATA_W] = wdata;
      if (wr_lo) acc_d[DATA_W-1:0]     = wdata;
      acc_en = 1'b1;
    end else if (step) begin
      if (dir_up && acc_q != ACC_MAX) begin
        acc_d  = acc_q + 1'b1;
        acc_en = 1'b1;
      end else if (!dir_up && acc_q != '0) begin
        acc_d  = acc_q - 1'b1;
        acc_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= ACC_MID;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end
endmodule

// File: rtl/cg_flags.sv
module cg_flags #(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] acc,
  input  logic [ACC_W-1:0] hi_lim,
  input  logic [ACC_W-1:0] lo_lim,
  input  logic             uv_in,
  input  logic             clr,
  output logic             flag_hi,
  output logic             flag_lo,
  output logic             flag_uv
);
  logic above;
  logic below;
  logic hi_d;
  logic lo_d;
  logic uv_d;

  always_comb begin
    above = acc > hi_lim;
    below = acc < lo_lim;
    hi_d  = above | (flag_hi & ~clr);
    lo_d  = below | (flag_lo & ~clr);
    uv_d  = uv_in | (flag_uv & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_hi <= 1'b0;
      flag_lo <= 1'b0;
      flag_uv <= 1'b0;
    end else begin
      flag_hi <= hi_d;
      flag_lo <= lo_d;
      flag_uv <= uv_d;
    end
  end
endmodule

// File: rtl/cgauge_top.sv
module cgauge_top
  import cg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int EXP_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              q_pulse,
  input  logic              q_up,
  input  logic              uv_in,
  input  logic              pin_in,
  output logic              pin_pull_low,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);
  localparam int ACC_W = 2 * DATA_W;
  localparam logic [DATA_W-1:0] CTRL_RST =
    DATA_W'(((1 << EXP_W) - 1) << CTRL_EXP_LSB);

  logic                rst_s1;
  logic                rst_ns;
  logic [DATA_W-1:0]   ctrl_q;
  logic [DATA_W-1:0]   ctrl_d;
  logic [ACC_W-1:0]    hi_thr_q;
  logic [ACC_W-1:0]    hi_thr_d;
  logic [ACC_W-1:0]    lo_thr_q;
  logic [ACC_W-1:0]    lo_thr_d;
  logic [DATA_W-1:0]   snap_q;
  logic [DATA_W-1:0]   snap_d;
  logic                snap_vld_q;
  logic                snap_vld_d;
  logic [ACC_W-1:0]    acc_q;
  logic                step;
  logic                preset;
  logic                acc_wr_hi;
  logic                acc_wr_lo;
  logic                stat_rd;
  logic                flag_hi;
  logic                flag_lo;
  logic                flag_uv;
  logic                shdn;
  pin_mode_e           pmode;
  reg_addr_e           addr;

  // reset: asserted asynchronously, released on the second edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_ns <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_ns <= rst_s1;
    end
  end

  always_comb begin
    addr      = reg_addr_e'(reg_addr);
    shdn      = ctrl_q[CTRL_SHDN_BIT];
    pmode     = pin_mode_e'(ctrl_q[CTRL_MODE_LSB +: 2]);
    preset    = (pmode == PM_CHGDONE) & pin_in;
    acc_wr_hi = reg_wr & (addr == A_ACCH);
    acc_wr_lo = reg_wr & (addr == A_ACCL);
    stat_rd   = reg_rd & (addr == A_STAT);
    pin_pull_low = (pmode == PM_ALERT) & (flag_hi | flag_lo | flag_uv);
  end

  // host-writable register next state
  always_comb begin
    ctrl_d   = ctrl_q;
    hi_thr_d = hi_thr_q;
    lo_thr_d = lo_thr_q;
    if (reg_wr) begin
      case (addr)
        A_CTRL:  ctrl_d                     = reg_wdata;
        A_HIH:   hi_thr_d[ACC_W-1:DATA_W]   = reg_wdata;
        A_HIL:   hi_thr_d[DATA_W-1:0]       = reg_wdata;
        A_LOH:   lo_thr_d[ACC_W-1:DATA_W]   = reg_wdata;
        A_LOL:   lo_thr_d[DATA_W-1:0]       = reg_wdata;
        default: ;
      endcase
    end
  end

  // low-byte capture for coherent two-byte reads
  always_comb begin
    snap_d     = snap_q;
    snap_vld_d = snap_vld_q;
    if (acc_wr_hi || acc_wr_lo) begin
      snap_vld_d = 1'b0;
    end else if (reg_rd && addr == A_ACCH) begin
      snap_d     = acc_q[DATA_W-1:0];
      snap_vld_d = 1'b1;
    end else if (reg_rd && addr == A_ACCL) begin
      snap_vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      ctrl_q     <= CTRL_RST;
      hi_thr_q   <= '1;
      lo_thr_q   <= '0;
      snap_q     <= '0;
      snap_vld_q <= 1'b0;
    end else begin
      ctrl_q     <= ctrl_d;
      hi_thr_q   <= hi_thr_d;
      lo_thr_q   <= lo_thr_d;
      snap_q     <= snap_d;
      snap_vld_q <= snap_vld_d;
    end
  end

  always_comb begin
    case (addr)
      A_STAT:  reg_rdata = DATA_W'({flag_hi, flag_lo, flag_uv, 1'b0});
      A_CTRL:  reg_rdata = ctrl_q;
      A_ACCH:  reg_rdata = acc_q[ACC_W-1:DATA_W];
      A_ACCL:  reg_rdata = snap_vld_q ? snap_q : acc_q[DATA_W-1:0];
      A_HIH:   reg_rdata = hi_thr_q[ACC_W-1:DATA_W];
      A_HIL:   reg_rdata = hi_thr_q[DATA_W-1:0];
      A_LOH:   reg_rdata = lo_thr_q[ACC_W-1:DATA_W];
      default: reg_rdata = lo_thr_q[DATA_W-1:0];
    endcase
  end

  cg_prescaler #(.EXP_W(EXP_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_ns),
    .run     (~shdn),
    .pulse   (q_pulse),
    .exp_sel (ctrl_q[CTRL_EXP_LSB +: EXP_W]),
    .step    (step)
  );

  cg_accum #(.DATA_W(DATA_W)) u_acc (
    .clk    (clk),
    .rst_n  (rst_ns),
    .step   (step),
    .dir_up (q_up),
    .preset (preset),
    .wr_hi  (acc_wr_hi),
    .wr_lo  (acc_wr_lo),
    .wdata  (reg_wdata),
    .acc_q  (acc_q)
  );

  cg_flags #(.ACC_W(ACC_W)) u_flg (
    .clk     (clk),
    .rst_n   (rst_ns),
    .acc     (acc_q),
    .hi_lim  (hi_thr_q),
    .lo_lim  (lo_thr_q),
    .uv_in   (uv_in),
    .clr     (stat_rd),
    .flag_hi (flag_hi),
    .flag_lo (flag_lo),
    .flag_uv (flag_uv)
  );
endmodule

// File: rtl/cg_checker.sv
module cg_checker #(
  parameter int ACC_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ACC_W-1:0]  acc_q,
  input logic [DATA_W-1:0] ctrl_q,
  input logic [ACC_W-1:0]  hi_thr_q,
  input logic              pin_in,
  input logic              acc_wr_hi,
  input logic              acc_wr_lo,
  input logic              flag_hi,
  input logic              flag_lo,
  input logic              flag_uv,
  input logic              pin_pull_low
);
  logic host_wr;
  logic chg_done;
  assign host_wr  = acc_wr_hi | acc_wr_lo;
  assign chg_done = (ctrl_q[2:1] == 2'b01) & pin_in;

  AST_SHDN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[0] && !host_wr && !chg_done) |=> $stable(acc_q)); // R4

  AST_PRESET_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    chg_done |=> (acc_q == {ACC_W{1'b1}})); // R10

  AST_NO_WRAP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q == {ACC_W{1'b1}} && !host_wr) |=> (acc_q >= {{(ACC_W-1){1'b1}}, 1'b0})); // R3

  AST_NO_WRAP_BOT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q == '0 && !host_wr && !chg_done) |=> (acc_q <= 1)); // R3

  AST_HI_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_hi) |-> $past(acc_q > hi_thr_q)); // R7

  AST_ALERT_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    pin_pull_low |-> (ctrl_q[2:1] == 2'b10 && (flag_hi || flag_lo || flag_uv))); // R9
endmodule

bind cgauge_top cg_checker #(.ACC_W(ACC_W), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_ns),
  .acc_q        (acc_q),
  .ctrl_q       (ctrl_q),
  .hi_thr_q     (hi_thr_q),
  .pin_in       (pin_in),
  .acc_wr_hi    (acc_wr_hi),
  .acc_wr_lo    (acc_wr_lo),
  .flag_hi      (flag_hi),
  .flag_lo      (flag_lo),
  .flag_uv      (flag_uv),
  .pin_pull_low (pin_pull_low)
);

// File: tb/sim_cgauge_top.sv
`timescale 1ns/1ps
module sim_cgauge_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       q_pulse = 1'b0;
  logic       q_up = 1'b0;
  logic       uv_in = 1'b0;
  logic       pin_in = 1'b0;
  logic       pin_pull_low;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  cgauge_top u0 (
    .clk(clk), .rst_n(rst_n), .q_pulse(q_pulse), .q_up(q_up),
    .uv_in(uv_in), .pin_in(pin_in), .pin_pull_low(pin_pull_low),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_PU = 2'd2, OP_PD = 2'd3;
  localparam logic [2:0] STAT = 3'd0, CTRL = 3'd1, ACCH = 3'd2, ACCL = 3'd3,
                         HIH = 3'd4, HIL = 3'd5, LOH = 3'd6, LOL = 3'd7;
  localparam int NVEC = 38;
  // {req[4], op[2], addr[3], data[8], expect[8]}
  localparam logic [24:0] VEC [NVEC] = '{
    {4'd1, OP_RD, CTRL, 8'h00, 8'h38},  // R1
    {4'd1, OP_RD, ACCH, 8'h00, 8'h7F},
    {4'd1, OP_RD, ACCL, 8'h00, 8'hFF},
    {4'd1, OP_RD, HIH,  8'h00, 8'hFF},
    {4'd1, OP_RD, HIL,  8'h00, 8'hFF},
    {4'd1, OP_RD, LOH,  8'h00, 8'h00},
    {4'd1, OP_RD, LOL,  8'h00, 8'h00},
    {4'd1, OP_RD, STAT, 8'h00, 8'h00},
    {4'd2, OP_WR, CTRL, 8'h00, 8'h00},  // R2 M=1
    {4'd2, OP_PU, STAT, 8'd3,  8'h00},
    {4'd2, OP_RD, ACCH, 8'h00, 8'h80},
    {4'd2, OP_RD, ACCL, 8'h00, 8'h02},
    {4'd2, OP_PD, STAT, 8'd5,  8'h00},
    {4'd2, OP_RD, ACCH, 8'h00, 8'h7F},
    {4'd2, OP_RD, ACCL, 8'h00, 8'hFD},
    {4'd2, OP_WR, CTRL, 8'h10, 8'h00},  // R2 M=4
    {4'd2, OP_PU, STAT, 8'd7,  8'h00},
    {4'd2, OP_RD, ACCL, 8'h00, 8'hFE},
    {4'd2, OP_PU, STAT, 8'd1,  8'h00},
    {4'd2, OP_RD, ACCL, 8'h00, 8'hFF},
    {4'd5, OP_WR, HIH,  8'h80, 8'h00},  // R5
    {4'd5, OP_WR, HIL,  8'h01, 8'h00},
    {4'd5, OP_RD, HIL,  8'h00, 8'h01},
    {4'd2, OP_WR, CTRL, 8'h00, 8'h00},
    {4'd7, OP_PU, STAT, 8'd3,  8'h00},  // R7 8002h above 8001h
    {4'd7, OP_RD, STAT, 8'h00, 8'h08},
    {4'd7, OP_PD, STAT, 8'd2,  8'h00},
    {4'd7, OP_RD, STAT, 8'h00, 8'h08},  // sticky
    {4'd7, OP_RD, STAT, 8'h00, 8'h00},  // cleared
    {4'd5, OP_WR, LOH,  8'h7F, 8'h00},
    {4'd5, OP_WR, LOL,  8'h00, 8'h00},
    {4'd4, OP_WR, CTRL, 8'h01, 8'h00},  // R4 shut down
    {4'd5, OP_WR, ACCH, 8'h7E, 8'h00},
    {4'd5, OP_WR, ACCL, 8'h10, 8'h00},
    {4'd4, OP_PU, STAT, 8'd5,  8'h00},  // R4 ignored
    {4'd4, OP_RD, ACCH, 8'h00, 8'h7E},
    {4'd4, OP_RD, ACCL, 8'h00, 8'h10},
    {4'd7, OP_RD, STAT, 8'h00, 8'h04}   // R7 low flag
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
    @(posedge clk);
  endtask

  task automatic rd(input string tag, input logic [2:0] a, input logic [7:0] exp);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 check(tag, reg_rdata, exp);
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic pulses(input int n, input logic up);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      q_pulse = 1'b1; q_up = up;
      @(posedge clk); #1;
      q_pulse = 1'b0;
    end
    @(posedge clk);
  endtask

  task automatic pin_chk(input string tag, input logic exp);
    @(negedge clk);
    check(tag, {7'd0, pin_pull_low}, {7'd0, exp});
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  initial begin
    fork
      begin
        do_reset();
        for (int v = 0; v < NVEC; v++) begin
          string tg;
          tg = $sformatf("R%0d vector %0d", VEC[v][24:21], v);
          case (VEC[v][20:19])
            OP_WR: wr(VEC[v][18:16], VEC[v][15:8]);
            OP_RD: rd(tg, VEC[v][18:16], VEC[v][7:0]);
            OP_PU: pulses(int'(VEC[v][15:8]), 1'b1);
            default: pulses(int'(VEC[v][15:8]), 1'b0);
          endcase
        end

        // R9 alert output with low flag set
        wr(CTRL, 8'h05);
        pin_chk("R9 alert pulls low", 1'b1);
        wr(LOH, 8'h00);
        rd("R7 status before clear", STAT, 8'h04);
        pin_chk("R9 alert released", 1'b0);

        // R8 undervoltage
        @(negedge clk); uv_in = 1'b1;
        @(posedge clk); #1 uv_in = 1'b0;
        pin_chk("R9 alert on undervoltage", 1'b1);
        wr(CTRL, 8'h01);
        pin_chk("R9 mode 00 no pull", 1'b0);
        wr(CTRL, 8'h07);
        pin_chk("R9 mode 11 no pull", 1'b0);
        rd("R8 undervoltage bit", STAT, 8'h02);
        rd("R8 undervoltage cleared", STAT, 8'h00);

        // R10 charge-complete preset, and R9 pin input ignored elsewhere
        wr(CTRL, 8'h00);
        @(negedge clk); pin_in = 1'b1;
        @(posedge clk); #1 pin_in = 1'b0;
        rd("R9 pin ignored in mode 00", ACCH, 8'h7E);
        wr(CTRL, 8'h04);
        @(negedge clk); pin_in = 1'b1;
        @(posedge clk); #1 pin_in = 1'b0;
        rd("R9 pin ignored in mode 10", ACCH, 8'h7E);
        wr(CTRL, 8'h02);
        @(negedge clk); pin_in = 1'b1; reg_wr = 1'b1; reg_addr = ACCH; reg_wdata = 8'h00;
        @(posedge clk); #1 pin_in = 1'b0; reg_wr = 1'b0;
        rd("R10 preset high byte", ACCH, 8'hFF);
        rd("R10 preset low byte", ACCL, 8'hFF);

        // R3 saturation at both ends
        wr(CTRL, 8'h00);
        pulses(3, 1'b1);
        rd("R3 top high byte", ACCH, 8'hFF);
        rd("R3 top low byte", ACCL, 8'hFF);
        pulses(1, 1'b0);
        rd("R3 step down from top", ACCL, 8'hFE);
        wr(CTRL, 8'h01);
        wr(ACCH, 8'h00);
        wr(ACCL, 8'h01);
        wr(CTRL, 8'h00);
        pulses(3, 1'b0);
        rd("R3 bottom high byte", ACCH, 8'h00);
        rd("R3 bottom low byte", ACCL, 8'h00);
        pulses(1, 1'b1);
        rd("R3 step up from bottom", ACCL, 8'h01);

        // R6 coherent two-byte read
        wr(CTRL, 8'h01);
        wr(ACCH, 8'h12);
        wr(ACCL, 8'hFF);
        wr(CTRL, 8'h00);
        rd("R6 high byte", ACCH, 8'h12);
        pulses(1, 1'b1);
        rd("R6 captured low byte", ACCL, 8'hFF);
        rd("R6 live low byte", ACCL, 8'h00);
        rd("R6 new high byte", ACCH, 8'h13);

        // R1 reset again, R2 default M=128
        do_reset();
        rd("R1 control after reset", CTRL, 8'h38);
        rd("R1 accum after reset", ACCH, 8'h7F);
        rd("R1 status after reset", STAT, 8'h00);
        pin_chk("R1 pin idle after reset", 1'b0);
        pulses(127, 1'b1);
        rd("R2 127 pulses no step hi", ACCH, 8'h7F);
        rd("R2 127 pulses no step lo", ACCL, 8'hFF);
        pulses(1, 1'b1);
        rd("R2 128th pulse hi", ACCH, 8'h80);
        rd("R2 128th pulse lo", ACCL, 8'h00);
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule